// File: doc/BRIEF.md
# Transmit Descriptor Mode Tracker

This block watches the stream of transmit descriptors and sorts each into a context descriptor or a data descriptor of one of three kinds. The kinds are plain (legacy), extended-offload and segmentation. It keeps a separate stored context for the extended and for the segmentation mode. A stored context stays in force across any number of packets until a new context descriptor overwrites it. The mode of each packet is taken from the kind of its first data descriptor.

Every accepted data descriptor produces a tag one cycle later. The tag gives the packet mode and marks the first and last descriptor of the packet. The block also enforces the ordering rules on the stream. A context load may not land inside an open packet. Kinds may not be mixed within a packet. An extended or segmentation descriptor may not arrive before its context has been loaded. A descriptor that breaks a rule is dropped and answered with a one-cycle error pulse and a code. The pulse leaves the stored contexts and the packet state exactly as they were.

Top module: `txd_mode_tracker`

## Requirements
- R1: While reset is held and in the first cycle after it, no tag or error is raised, no packet is open and both context valid flags are low. `in_ready` is high from the second cycle after reset release onward.
- R2: Field encodings: `in_kind` is 2'b00 legacy data, 2'b01 extended data, 2'b10 segmentation data, 2'b11 context. `in_ctx_sel` 0 targets the extended context and 1 targets the segmentation context. `tag_mode` and `pkt_mode` use the data encodings of `in_kind`.
- R3: A context descriptor accepted while no packet is open writes `in_ctx` into the selected context and sets its valid flag, visible one cycle after acceptance. The other context is unchanged and no tag is produced.
- R4: A stored context and its valid flag keep their values across any number of packets until another accepted context descriptor for the same mode replaces them. A valid flag never falls outside reset.
- R5: An accepted data descriptor that breaks no rule raises `tag_valid` for one cycle, one cycle after acceptance. The tag carries `tag_mode` equal to its kind and `tag_last` equal to its end-of-packet bit.
- R6: The first accepted data descriptor when no packet is open opens a packet in its mode and gets `tag_first`=1. Later descriptors of that packet get `tag_first`=0. A descriptor with end-of-packet set closes the packet, and a single descriptor with end-of-packet set is a complete packet.
- R7: A context descriptor accepted while a packet is open is dropped and raises `err_pulse` with `err_code`=1. The contexts and the packet state are left unchanged.
- R8: A data descriptor whose kind differs from the open packet's mode is dropped and raises `err_pulse` with `err_code`=2. The packet stays open in its original mode, and the descriptor's end-of-packet bit has no effect.
- R9: An extended or segmentation data descriptor that would not be a mixing error, and whose context valid flag is low, is dropped and raises `err_pulse` with `err_code`=3. The packet state is unchanged.
- R10: `err_pulse` and `tag_valid` are never high in the same cycle. Each rejected descriptor gives exactly one error cycle, and `err_code` is 0 whenever `err_pulse` is low.
- R11: Legacy data descriptors need no stored context and are tagged whatever the state of the context valid flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Descriptor present |
| in_ready | output | 1 | Descriptor can be accepted |
| in_kind | input | 2 | Descriptor kind |
| in_ctx_sel | input | 1 | Context target for a context descriptor |
| in_eop | input | 1 | End-of-packet bit |
| in_ctx | input | CTX_W | Context payload |
| tag_valid | output | 1 | Tag for an accepted data descriptor |
| tag_mode | output | 2 | Mode of the tagged descriptor |
| tag_first | output | 1 | Tagged descriptor opened its packet |
| tag_last | output | 1 | Tagged descriptor closed its packet |
| pkt_open | output | 1 | A packet is in progress |
| pkt_mode | output | 2 | Mode of the open packet |
| ext_ctx | output | CTX_W | Stored extended context |
| ext_ctx_vld | output | 1 | Extended context loaded |
| seg_ctx | output | CTX_W | Stored segmentation context |
| seg_ctx_vld | output | 1 | Segmentation context loaded |
| err_pulse | output | 1 | Rule violation, descriptor dropped |
| err_code | output | 2 | 1 context in packet, 2 kind mix, 3 missing context |

## Verification
Some properties are checked by assertions on every cycle. Tags and errors never coincide. Both contexts hold steady on any cycle after one where a packet was open. A continuation tag repeats the mode the packet was opened with. Extended and segmentation tags only appear once their context is valid. Valid flags never fall. Other behaviour can only be shown by the bench's scenarios, which compare every output against a reference model. These include the exact stored payloads, the choice of error code when several rules could apply, and the fact that a dropped descriptor's end-of-packet bit leaves the packet open. Contexts persisting across many packets and back-to-back violations are exercised the same way.

// File: rtl/txd_mode_tracker.sv
module txd_mode_tracker #(
  parameter int CTX_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_kind,
  input  logic             in_ctx_sel,
  input  logic             in_eop,
  input  logic [CTX_W-1:0] in_ctx,
  output logic             tag_valid,
  output logic [1:0]       tag_mode,
  output logic             tag_first,
  output logic             tag_last,
  output logic             pkt_open,
  output logic [1:0]       pkt_mode,
  output logic [CTX_W-1:0] ext_ctx,
  output logic             ext_ctx_vld,
  output logic [CTX_W-1:0] seg_ctx,
  output logic             seg_ctx_vld,
  output logic             err_pulse,
  output logic [1:0]       err_code
);

  localparam logic [1:0] K_LEG = 2'b00;
  localparam logic [1:0] K_EXT = 2'b01;
  localparam logic [1:0] K_SEG = 2'b10;
  localparam logic [1:0] K_CTX = 2'b11;

  localparam logic [1:0] E_NONE  = 2'd0;
  localparam logic [1:0] E_INPKT = 2'd1;
  localparam logic [1:0] E_MIX   = 2'd2;
  localparam logic [1:0] E_NOCTX = 2'd3;

  logic       ready_q;
  logic       acc, is_ctx, has_ctx, bad, ok_ctx, ok_data;
  logic [1:0] code;

  assign in_ready = ready_q;
  assign acc      = in_valid & ready_q;
  assign is_ctx   = (in_kind == K_CTX);
  assign has_ctx  = (in_kind == K_EXT) ? ext_ctx_vld :
                    (in_kind == K_SEG) ? seg_ctx_vld : 1'b1;

  always_comb begin
    code = E_NONE;
    if (is_ctx) begin
      if (pkt_open) code = E_INPKT;
    end else if (pkt_open && in_kind != pkt_mode) begin
      code = E_MIX;
    end else if (!has_ctx) begin
      code = E_NOCTX;
    end
  end

  assign bad     = acc && (code != E_NONE);
  assign ok_ctx  = acc && is_ctx && !bad;
  assign ok_data = acc && !is_ctx && !bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q     <= 1'b0;
      tag_valid   <= 1'b0;
      tag_mode    <= K_LEG;
      tag_first   <= 1'b0;
      tag_last    <= 1'b0;
      pkt_open    <= 1'b0;
      pkt_mode    <= K_LEG;
      ext_ctx     <= '0;
      ext_ctx_vld <= 1'b0;
      seg_ctx     <= '0;
      seg_ctx_vld <= 1'b0;
      err_pulse   <= 1'b0;
      err_code    <= E_NONE;
    end else begin
      ready_q   <= 1'b1;
      tag_valid <= ok_data;
      err_pulse <= bad;
      err_code  <= bad ? code : E_NONE;
      if (ok_data) begin
        tag_mode  <= in_kind;
        tag_first <= !pkt_open;
        tag_last  <= in_eop;
        pkt_open  <= !in_eop;
        pkt_mode  <= in_kind;
      end
      if (ok_ctx && !in_ctx_sel) begin
        ext_ctx     <= in_ctx;
        ext_ctx_vld <= 1'b1;
      end
      if (ok_ctx && in_ctx_sel) begin
        seg_ctx     <= in_ctx;
        seg_ctx_vld <= 1'b1;
      end
    end
  end

  // R10
  err_tag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_pulse && tag_valid));

  // R7
  ctx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pkt_open) |-> ($stable(ext_ctx) && $stable(seg_ctx)));

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_valid && !tag_first) |-> (tag_mode == $past(pkt_mode)));

  // R9
  ext_needs_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_valid && tag_mode == K_EXT) |-> ext_ctx_vld);

  // R9
  seg_needs_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_valid && tag_mode == K_SEG) |-> seg_ctx_vld);

  // R4
  vld_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(ext_ctx_vld) && !$fell(seg_ctx_vld));

  // R6
  first_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tag_valid |-> (tag_first == !$past(pkt_open)));

endmodule

// File: tb/tb_txd_mode_tracker.sv
`timescale 1ns/1ps
module tb_txd_mode_tracker;
  localparam int CTX_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [1:0] in_kind = 2'b00;
  logic in_ctx_sel = 1'b0;
  logic in_eop = 1'b0;
  logic [CTX_W-1:0] in_ctx = '0;
  logic tag_valid, tag_first, tag_last, pkt_open, ext_ctx_vld, seg_ctx_vld, err_pulse;
  logic [1:0] tag_mode, pkt_mode, err_code;
  logic [CTX_W-1:0] ext_ctx, seg_ctx;

  always #10 clk = ~clk;

  txd_mode_tracker #(.CTX_W(CTX_W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_ctx_sel(in_ctx_sel), .in_eop(in_eop), .in_ctx(in_ctx),
    .tag_valid(tag_valid), .tag_mode(tag_mode), .tag_first(tag_first), .tag_last(tag_last),
    .pkt_open(pkt_open), .pkt_mode(pkt_mode), .ext_ctx(ext_ctx), .ext_ctx_vld(ext_ctx_vld),
    .seg_ctx(seg_ctx), .seg_ctx_vld(seg_ctx_vld), .err_pulse(err_pulse), .err_code(err_code));

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic e_tv, e_tf, e_tl, e_open, e_extv, e_segv, e_err;
  logic [1:0] e_tm, e_pm, e_code;
  logic [CTX_W-1:0] e_ext, e_seg;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R2 encodings: 00 legacy, 01 ext, 10 seg, 11 context; sel 0 ext, 1 seg
  function automatic logic [1:0] exp_code(logic [1:0] k, logic open, logic [1:0] pm,
                                          logic xv, logic sv);
    if (k == 2'b11) return open ? 2'd1 : 2'd0;
    if (open && k != pm) return 2'd2;
    if ((k == 2'b01 && !xv) || (k == 2'b10 && !sv)) return 2'd3;
    return 2'd0;
  endfunction

  task automatic compare();
    string rq;
    chk(tag_valid == e_tv, "R5 tag_valid", tag_valid, e_tv);
    chk(err_pulse == e_err, e_code == 2'd1 ? "R7 err_pulse" : e_code == 2'd2 ? "R8 err_pulse" :
        e_code == 2'd3 ? "R9 err_pulse" : "R10 err_pulse", err_pulse, e_err);
    chk(err_code == e_code, "R10 err_code", err_code, e_code);
    chk(!(tag_valid && err_pulse), "R10 exclusive", {tag_valid, err_pulse}, 0);
    if (e_tv) begin
      rq = (e_tm == 2'b00) ? "R11 tag_mode legacy" : "R5 tag_mode";
      chk(tag_mode == e_tm, rq, tag_mode, e_tm);
      chk(tag_last == e_tl, "R5 tag_last", tag_last, e_tl);
      chk(tag_first == e_tf, "R6 tag_first", tag_first, e_tf);
    end
    chk(pkt_open == e_open, "R6 pkt_open", pkt_open, e_open);
    if (e_open) chk(pkt_mode == e_pm, "R8 pkt_mode", pkt_mode, e_pm);
    chk(ext_ctx_vld == e_extv && ext_ctx == e_ext, "R3 ext context", {ext_ctx_vld, ext_ctx}, {e_extv, e_ext});
    chk(seg_ctx_vld == e_segv && seg_ctx == e_seg, "R4 seg context", {seg_ctx_vld, seg_ctx}, {e_segv, e_seg});
  endtask

  task automatic step(input logic v, input logic [1:0] k, input logic s, input logic e,
                      input logic [CTX_W-1:0] d);
    logic [1:0] c;
    @(negedge clk);
    compare();
    in_valid = v; in_kind = k; in_ctx_sel = s; in_eop = e; in_ctx = d;
    c = exp_code(k, e_open, e_pm, e_extv, e_segv);
    e_tv = 1'b0; e_err = 1'b0; e_code = 2'd0;
    if (v) begin
      if (c != 2'd0) begin
        e_err = 1'b1; e_code = c;
      end else if (k == 2'b11) begin
        if (!s) begin e_ext = d; e_extv = 1'b1; end
        else    begin e_seg = d; e_segv = 1'b1; end
      end else begin
        e_tv = 1'b1; e_tm = k; e_tf = !e_open; e_tl = e; e_open = !e; e_pm = k;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    e_tv = 0; e_tf = 0; e_tl = 0; e_open = 0; e_extv = 0; e_segv = 0; e_err = 0;
    e_tm = 0; e_pm = 0; e_code = 0; e_ext = '0; e_seg = '0;
    repeat (3) @(negedge clk);
    // R1 state under reset
    chk(!tag_valid && !err_pulse && !pkt_open && !ext_ctx_vld && !seg_ctx_vld && !in_ready,
        "R1 reset state", {tag_valid, err_pulse, pkt_open, ext_ctx_vld, seg_ctx_vld, in_ready}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
    // directed corners
    step(1, 2'b01, 0, 1, 32'h0);            // R9 ext with no context
    step(1, 2'b00, 0, 0, 32'h0);            // R11 legacy opens
    step(1, 2'b11, 0, 0, 32'hDEAD_BEEF);    // R7 context inside packet
    step(1, 2'b10, 0, 1, 32'h0);            // R8 mix, eop ignored
    step(1, 2'b00, 0, 1, 32'h0);            // R6 close
    step(1, 2'b11, 0, 0, 32'h1234_5678);    // R3 load ext
    step(1, 2'b11, 1, 0, 32'h9ABC_DEF0);    // R3 load seg
    step(1, 2'b01, 0, 0, 32'h0);            // R5 ext open
    step(1, 2'b01, 0, 1, 32'h0);
    step(1, 2'b10, 0, 1, 32'h0);            // R6 single descriptor packet
    step(1, 2'b11, 0, 0, 32'h0BAD_F00D);    // R4 replace ext only
    step(1, 2'b00, 0, 1, 32'h0);
    step(0, 2'b00, 0, 0, 32'h0);
    // constrained random
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [1:0] k;
      r = $urandom % 10;
      k = (r < 1) ? 2'b11 : (r < 4) ? 2'b00 : (r < 7) ? 2'b01 : 2'b10;
      if (e_open && ($urandom % 4 != 0) && k != 2'b11) k = e_pm;
      step(($urandom % 5) != 0, k, $urandom % 2, ($urandom % 3) == 0, $urandom);
    end
    step(0, 2'b00, 0, 0, 32'h0);
    step(0, 2'b00, 0, 0, 32'h0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule